// File: doc/BRIEF.md
# Serial LMS Adaptive Noise Canceller

This block removes correlated noise from a signal by adaptive filtering. For each iteration it takes one signed 8-bit sample of the noisy signal and one signed 8-bit sample of a noise reference. An 8-tap FIR filter runs over the recent reference history to estimate the noise in the noisy sample. The estimate is subtracted from the sample, and the saturated difference is the cleaned output. The same difference then drives a least-mean-square update of every tap weight. Over many iterations the weights converge towards the path that couples the reference into the noisy signal.

The arithmetic is shared to save area. One sequential shift-add signed multiplier and one 12-bit adder do all the work, and a small controller with a tap counter sequences them. The tap weights (12-bit signed) and the reference history (8 samples) sit in two rotating register stacks. Each stack presents only its head entry, and both stacks advance in step. One iteration takes 162 clock cycles.

The sample input is a valid/ready stream. A sample transfers on a rising edge where `in_valid` and `in_ready` are both high. While the block is busy, `in_ready` is low and any offered sample is not taken, so the source must hold it or offer it again later. The output has no back-pressure: `out_valid` is a one-cycle strobe, and the receiver must capture `out_data` in that cycle (`out_data` then holds its value until the next result).

Top module: `lms_canceller`

## Requirements
- R1: `in_ready` is high only while idle. A sample is accepted on a rising edge with `in_valid` and `in_ready` both high. A sample offered while `in_ready` is low is ignored and changes neither the weights nor the history.
- R2: `out_valid` is high for exactly one cycle. It rises 81 clock edges after the accepting edge, and `out_data` carries that iteration's result in that cycle.
- R3: `in_ready` falls at the accepting edge and stays low until it rises 161 edges after it. Consecutive iterations can therefore start 162 cycles apart.
- R4: At each accepted sample the new reference becomes tap 0, earlier references move one tap older, and the sample that was at tap 7 is dropped.
- R5: The noise estimate is the sum over taps k of floor((c_k·x_k + 64) / 128). Here c_k is the signed upper 8 bits of the 12-bit weight k (floor of weight / 16), and x_k is the reference at tap k.
- R6: The error is the noisy sample minus the estimate, clamped to the range -128..127. `out_data` is this error in two's complement.
- R7: After the output, each weight k becomes weight + floor(e·x_k / 2^MU_SHIFT), clamped to -2048..2047. All taps use the same error e of the current iteration (MU_SHIFT defaults to 7).
- R8: Synchronous active-high `rst` clears all weights and the history and returns the block to idle (`in_ready`=1, `out_valid`=0), including when it arrives mid-iteration. The first result after reset therefore equals the noisy sample.
- R9: When `rst` and `in_valid` are high in the same cycle, reset wins and the offered sample is not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_noisy | input | 8 | Noisy signal sample, signed |
| in_ref | input | 8 | Noise reference sample, signed |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 8 | Cleaned sample (saturated error), signed |

## Verification
Two events can land on the same edge: a new sample offered in `in_valid`, and another function that claims the block in that cycle. One case is reset, since the bench raises `rst` in the very cycle it offers a sample. It then expects no result strobe and a later first output equal to the raw noisy value. The other case is the busy weight-update phase. The bench pulses `in_valid` with distinct data partway through an iteration. It judges the result by whether every later output still matches a reference model that never saw that sample. A second instance with a step shift of zero drives the weights and error into their clamps, so saturation and adaptation are exercised in the same iterations.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // Controller phases: filter pass, error capture, weight-update pass
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FSTART,
    ST_FWAIT,
    ST_ERR,
    ST_USTART,
    ST_UWAIT
  } lms_state_t;

  // Operations on a rotating register stack
  typedef enum logic [1:0] {
    STK_HOLD,    // keep contents
    STK_ROT,     // head moves to tail, next entry becomes head
    STK_ROT_WR,  // as STK_ROT, but tail receives din instead of old head
    STK_PUSH     // din becomes head, every entry moves one deeper, last dropped
  } stk_op_t;

endpackage

// File: rtl/lms_rot_stack.sv
module lms_rot_stack
  import lms_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  stk_op_t      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] head
);

  logic [W-1:0] ent [N];
  logic [W-1:0] nxt [N];

  generate
    if (N == 1) begin : g_single
      always_comb begin
        nxt[0] = ent[0];
        if (op == STK_ROT_WR || op == STK_PUSH) nxt[0] = din;
      end
    end else begin : g_multi
      always_comb begin
        for (int i = 0; i < N; i++) nxt[i] = ent[i];
        case (op)
          STK_ROT: begin
            for (int i = 0; i < N - 1; i++) nxt[i] = ent[i+1];
            nxt[N-1] = ent[0];
          end
          STK_ROT_WR: begin
            for (int i = 0; i < N - 1; i++) nxt[i] = ent[i+1];
            nxt[N-1] = din;
          end
          STK_PUSH: begin
            nxt[0] = din;
            for (int i = 1; i < N; i++) nxt[i] = ent[i-1];
          end
          default: ;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;  // R8
    end else begin
      for (int i = 0; i < N; i++) ent[i] <= nxt[i];
    end
  end

  assign head = ent[0];

endmodule

// File: rtl/lms_smul.sv
// Sequential signed multiplier: magnitudes shift-added over W steps.
module lms_smul #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic                  done,
  output logic signed [2*W-1:0] prod
);

  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [PW-1:0] mcand_q, sum_q;
  logic [W-1:0]  mplr_q;
  logic          neg_q, busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  a_mag, b_mag;

  assign a_mag = a[W-1] ? W'(-a) : W'(a);
  assign b_mag = b[W-1] ? W'(-b) : W'(b);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      sum_q   <= '0;
      mplr_q  <= '0;
      neg_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        mcand_q <= PW'(a_mag);
        mplr_q  <= b_mag;
        sum_q   <= '0;
        neg_q   <= a[W-1] ^ b[W-1];
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (mplr_q[0]) sum_q <= sum_q + mcand_q;
        mcand_q <= mcand_q << 1;
        mplr_q  <= mplr_q >> 1;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign prod = neg_q ? -$signed(sum_q) : $signed(sum_q);

endmodule

// File: rtl/lms_ctrl.sv
module lms_ctrl
  import lms_pkg::*;
#(
  parameter int NTAP = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  logic    mul_done,
  output logic    in_ready,
  output logic    in_fire,
  output logic    mul_start,
  output logic    sel_upd,
  output logic    acc_clr,
  output logic    acc_en,
  output logic    err_en,
  output stk_op_t hist_op,
  output stk_op_t wgt_op
);

  localparam int KW = (NTAP > 1) ? $clog2(NTAP) : 1;

  lms_state_t state_q, state_d;
  logic [KW-1:0] k_q, k_d;
  logic tap_last;

  assign tap_last = (k_q == KW'(NTAP - 1));
  assign in_ready = (state_q == ST_IDLE);          // R1
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    state_d   = state_q;
    k_d       = k_q;
    mul_start = 1'b0;
    sel_upd   = 1'b0;
    acc_clr   = 1'b0;
    acc_en    = 1'b0;
    err_en    = 1'b0;
    hist_op   = STK_HOLD;
    wgt_op    = STK_HOLD;
    case (state_q)
      ST_IDLE: begin
        if (in_fire) begin
          hist_op = STK_PUSH;                      // R4
          acc_clr = 1'b1;
          k_d     = '0;
          state_d = ST_FSTART;
        end
      end
      ST_FSTART: begin
        mul_start = 1'b1;
        state_d   = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mul_done) begin
          acc_en  = 1'b1;                          // R5
          hist_op = STK_ROT;
          wgt_op  = STK_ROT;
          if (tap_last) begin
            k_d     = '0;
            state_d = ST_ERR;
          end else begin
            k_d     = k_q + 1'b1;
            state_d = ST_FSTART;
          end
        end
      end
      ST_ERR: begin
        err_en  = 1'b1;                            // R6
        state_d = ST_USTART;
      end
      ST_USTART: begin
        mul_start = 1'b1;
        sel_upd   = 1'b1;
        state_d   = ST_UWAIT;
      end
      ST_UWAIT: begin
        sel_upd = 1'b1;
        if (mul_done) begin
          wgt_op  = STK_ROT_WR;                    // R7
          hist_op = STK_ROT;
          if (tap_last) begin
            k_d     = '0;
            state_d = ST_IDLE;
          end else begin
            k_d     = k_q + 1'b1;
            state_d = ST_USTART;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;                          // R8 R9
      k_q     <= '0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
    end
  end

endmodule

// File: rtl/lms_dpath.sv
// Accumulator, error saturation and weight-update arithmetic.
module lms_dpath #(
  parameter int DW       = 8,
  parameter int WW       = 12,
  parameter int MU_SHIFT = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_fire,
  input  logic [DW-1:0]          in_noisy,
  input  logic                   acc_clr,
  input  logic                   acc_en,
  input  logic                   err_en,
  input  logic signed [2*DW-1:0] prod,
  input  logic signed [WW-1:0]   w_head,
  output logic signed [WW-1:0]   w_next,
  output logic signed [DW-1:0]   err_q,
  output logic                   out_valid
);

  localparam int PW  = 2 * DW;
  localparam int SW  = ((WW > PW) ? WW : PW) + 1;
  localparam int RSH = DW - 1;

  localparam logic signed [WW:0]   EMAX = (WW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [WW:0]   EMIN = -(WW+1)'(1 << (DW - 1));
  localparam logic signed [SW-1:0] WMAX = SW'((1 << (WW - 1)) - 1);
  localparam logic signed [SW-1:0] WMIN = -SW'(1 << (WW - 1));

  logic signed [DW-1:0] noisy_q;
  logic signed [WW-1:0] acc_q;
  logic signed [PW:0]   prod_ext, prod_rnd;
  logic signed [WW-1:0] term;
  logic signed [WW:0]   diff;
  logic signed [DW-1:0] err_sat;
  logic signed [PW-1:0] delta;
  logic signed [SW-1:0] wsum;

  // R5: rounded product, scaled back to sample units
  assign prod_ext = (PW+1)'(prod);
  assign prod_rnd = prod_ext + (PW+1)'(1 << (RSH - 1));
  assign term     = WW'(prod_rnd >>> RSH);

  // R6: error and clamp
  assign diff = (WW+1)'(noisy_q) - (WW+1)'(acc_q);
  always_comb begin
    if (diff > EMAX)      err_sat = EMAX[DW-1:0];
    else if (diff < EMIN) err_sat = EMIN[DW-1:0];
    else                  err_sat = diff[DW-1:0];
  end

  // R7: step-scaled correction and clamp
  assign delta = prod >>> MU_SHIFT;
  assign wsum  = SW'(w_head) + SW'(delta);
  always_comb begin
    if (wsum > WMAX)      w_next = WMAX[WW-1:0];
    else if (wsum < WMIN) w_next = WMIN[WW-1:0];
    else                  w_next = wsum[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      noisy_q   <= '0;
      acc_q     <= '0;
      err_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= err_en;                         // R2
      if (in_fire) noisy_q <= $signed(in_noisy);
      if (acc_clr) acc_q <= '0;
      else if (acc_en) acc_q <= acc_q + term;
      if (err_en) err_q <= err_sat;
    end
  end

endmodule

// File: rtl/lms_canceller.sv
module lms_canceller
  import lms_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NTAP     = 8,
  parameter int WW       = 12,
  parameter int MU_SHIFT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_noisy,
  input  logic [DW-1:0] in_ref,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int PW = 2 * DW;

  stk_op_t hist_op, wgt_op;
  logic in_fire, mul_start, mul_done, sel_upd, acc_clr, acc_en, err_en;
  logic [DW-1:0]        x_head;
  logic [WW-1:0]        w_head;
  logic signed [WW-1:0] w_next;
  logic signed [DW-1:0] err_q, mul_a, mul_b;
  logic signed [PW-1:0] prod;

  lms_ctrl #(.NTAP(NTAP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .mul_done (mul_done),
    .in_ready (in_ready),
    .in_fire  (in_fire),
    .mul_start(mul_start),
    .sel_upd  (sel_upd),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .err_en   (err_en),
    .hist_op  (hist_op),
    .wgt_op   (wgt_op)
  );

  // R4: reference history, head is the tap under work
  lms_rot_stack #(.W(DW), .N(NTAP)) u_hist (
    .clk (clk),
    .rst (rst),
    .op  (hist_op),
    .din (in_ref),
    .head(x_head)
  );

  // Tap weights, rewritten at the tail during the update pass
  lms_rot_stack #(.W(WW), .N(NTAP)) u_wgt (
    .clk (clk),
    .rst (rst),
    .op  (wgt_op),
    .din (w_next),
    .head(w_head)
  );

  // Shared multiplier: coefficient x reference, or error x reference
  assign mul_a = sel_upd ? err_q : $signed(w_head[WW-1 -: DW]);
  assign mul_b = $signed(x_head);

  lms_smul #(.W(DW)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .start(mul_start),
    .a    (mul_a),
    .b    (mul_b),
    .done (mul_done),
    .prod (prod)
  );

  lms_dpath #(.DW(DW), .WW(WW), .MU_SHIFT(MU_SHIFT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .in_fire  (in_fire),
    .in_noisy (in_noisy),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .err_en   (err_en),
    .prod     (prod),
    .w_head   ($signed(w_head)),
    .w_next   (w_next),
    .err_q    (err_q),
    .out_valid(out_valid)
  );

  assign out_data = err_q;

endmodule

// File: rtl/lms_canceller_chk.sv
module lms_canceller_chk #(
  parameter int DW   = 8,
  parameter int NTAP = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);

  localparam int OUT_LAT  = NTAP * (DW + 2) + 1;
  localparam int ITER_LAT = 2 * NTAP * (DW + 2) + 1;

  logic [15:0] cnt_q;
  logic        active_q;

  // Edges elapsed since the last accepted sample
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q && cnt_q != 16'hFFFF) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);                                               // R2
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (active_q && cnt_q == 16'(OUT_LAT)));                      // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);                                   // R3
  AST_READY_RETURN: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (active_q && cnt_q == 16'(ITER_LAT)));               // R3
  AST_OUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);                                                // R3
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));                                // R8

endmodule

bind lms_canceller lms_canceller_chk #(.DW(DW), .NTAP(NTAP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid)
);

// File: tb/lms_canceller_tb.sv
`timescale 1ns/1ps
module lms_canceller_tb;

  localparam int DW       = 8;
  localparam int NTAP     = 8;
  localparam int OUT_LAT  = NTAP * (DW + 2) + 1;
  localparam int ITER_LAT = 2 * NTAP * (DW + 2) + 1;
  localparam int NV       = 14;
  // {noisy, reference} per iteration
  localparam int STIM [NV][2] = '{
    '{100, 0}, '{-50, 30}, '{127, 127}, '{-128, -128}, '{127, -128},
    '{-128, 127}, '{60, 64}, '{64, 64}, '{-20, -90}, '{90, 90},
    '{0, 0}, '{-128, 0}, '{55, -33}, '{127, 127}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_noisy = '0, in_ref = '0;
  logic in_ready, in_ready2, out_valid, out_valid2;
  logic [DW-1:0] out_data, out_data2;

  int n_chk = 0;
  int n_fail = 0;
  int wt [2][NTAP];
  int hx [NTAP];
  int mu [2] = '{7, 0};

  always #2 clk = ~clk;

  lms_canceller #(.MU_SHIFT(7)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_noisy(in_noisy), .in_ref(in_ref), .out_valid(out_valid), .out_data(out_data));

  lms_canceller #(.MU_SHIFT(0)) u_dut_mu0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready2),
    .in_noisy(in_noisy), .in_ref(in_ref), .out_valid(out_valid2), .out_data(out_data2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < NTAP; k++) wt[s][k] = 0;
    for (int k = 0; k < NTAP; k++) hx[k] = 0;
  endtask

  // Model of R4..R7 for both step sizes
  task automatic model_iter(input int noisy, input int rf, output int e0, output int e1);
    int est, e;
    int es [2];
    for (int k = NTAP - 1; k > 0; k--) hx[k] = hx[k-1];
    hx[0] = rf;
    for (int s = 0; s < 2; s++) begin
      est = 0;
      for (int k = 0; k < NTAP; k++) est += ((wt[s][k] >>> 4) * hx[k] + 64) >>> 7;
      e = clamp(noisy - est, -128, 127);
      for (int k = 0; k < NTAP; k++)
        wt[s][k] = clamp(wt[s][k] + ((e * hx[k]) >>> mu[s]), -2048, 2047);
      es[s] = e;
    end
    e0 = es[0];
    e1 = es[1];
  endtask

  task automatic run_iter(input int noisy, input int rf, input bit inject);
    int e0, e1;
    model_iter(noisy, rf, e0, e1);
    in_valid = 1'b1;
    in_noisy = DW'(noisy);
    in_ref   = DW'(rf);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int m = 1; m <= ITER_LAT; m++) begin
      @(negedge clk);
      if (m == 1) chk(in_ready == 1'b0, "R3 ready low after accept", int'(in_ready), 0);
      if (m == OUT_LAT - 1) chk(out_valid == 1'b0, "R2 strobe early", int'(out_valid), 0);
      if (m == OUT_LAT) begin
        chk(out_valid == 1'b1, "R2 strobe on time", int'(out_valid), 1);
        chk(int'($signed(out_data)) == e0, "R4 R5 R6 output", int'($signed(out_data)), e0);
        chk(out_valid2 && int'($signed(out_data2)) == e1, "R7 output with clamped weights",
            int'($signed(out_data2)), e1);
      end
      if (m == OUT_LAT + 1) chk(out_valid == 1'b0, "R2 strobe one cycle", int'(out_valid), 0);
      if (inject && m == 20) begin
        in_valid = 1'b1;
        in_noisy = 8'h9C;
        in_ref   = 8'h63;
      end
      if (inject && m == 21) begin
        chk(in_ready == 1'b0, "R1 busy offer not ready", int'(in_ready), 0);
        in_valid = 1'b0;
      end
      if (m == ITER_LAT - 1) chk(in_ready == 1'b0, "R3 ready early", int'(in_ready), 0);
      if (m == ITER_LAT) chk(in_ready && in_ready2, "R3 ready returns", int'(in_ready), 1);
    end
  endtask

  task automatic expect_quiet(input string tag, input int cycles);
    bit seen = 1'b0;
    for (int m = 0; m < cycles; m++) begin
      @(negedge clk);
      if (out_valid || out_valid2) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
    chk(in_ready == 1'b1, tag, int'(in_ready), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int e0, e1;
    model_reset();
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R8 reset no strobe", int'(out_valid), 0);

    // R8: zero weights after reset, first output equals the noisy sample
    run_iter(STIM[0][0], STIM[0][1], 1'b0);

    // Table walk, back-to-back iterations
    for (int v = 1; v < NV; v++) run_iter(STIM[v][0], STIM[v][1], 1'b0);

    // R1: sample offered mid-iteration must leave no trace
    run_iter(-77, 41, 1'b1);
    run_iter(33, -12, 1'b0);
    run_iter(-5, 100, 1'b0);

    // R8: reset in the middle of an iteration
    in_valid = 1'b1;
    in_noisy = DW'(20);
    in_ref   = DW'(20);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    expect_quiet("R8 mid-iteration reset", 100);
    run_iter(77, 5, 1'b0);

    // R9: reset and an offered sample in the same cycle
    rst = 1'b1;
    in_valid = 1'b1;
    in_noisy = DW'(50);
    in_ref   = DW'(50);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    model_reset();
    expect_quiet("R9 reset beats offer", 100);
    run_iter(-90, 70, 1'b0);
    run_iter(120, -60, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule